// File: doc/BRIEF.md
# Automatic Software Flow-Control Injector

This block sits beside a UART receive FIFO and its transmitter. It watches the receive fill count and, when enabled, inserts software flow-control bytes into the outgoing stream. A two-bit select picks one of four fill thresholds. When the count reaches the selected threshold, the block waits two character times and then asks the transmitter to send a pause pair: the first pause byte, then the second. After the pair has gone out, the block stays paused. When the count falls to the release level, which is one table step lower, it asks for a resume pair.

The character time is given in clock cycles on `charTicks`. The transmitter sees a request line and a byte. It raises `injAck` in the cycle in which it loads that byte at a character boundary. Injected bytes therefore never cut into a frame that is already on the line. The FIFO, the shift registers and the baud generator are outside this block.

Top module: `swflow_ctrl`

## Requirements
- R1: The threshold is 8, 16, 24 or 28 for `trigSel` = 0, 1, 2 or 3. The threshold counts as reached when `fifoCount` is greater than or equal to it. A count one below the threshold starts nothing.
- R2: The block may be idle, with the count at or above the threshold, sampled at some rising edge E. If the count stays there, `injReq` rises together with `injByte` = `pauseA`. It is first seen high after exactly 2*`charTicks`+1 rising edges, counting E.
- R3: A pair is always sent in the order first byte (`pauseA` or `resumeA`), then second byte (`pauseB` or `resumeB`). While `injReq` is high and `injAck` is low, `injReq` and `injByte` hold steady. After the edge that samples an acknowledge of the first byte, `injReq` stays high with the second byte. After the edge that samples an acknowledge of the second byte, `injReq` goes low.
- R4: The release level is 0, 8, 16 or 24 for `trigSel` = 0, 1, 2 or 3. In the paused state, the first rising edge that samples `fifoCount` at or below the release level raises `injReq` with `resumeA`. A count one above the release level starts nothing.
- R5: Once a pause pair has been sent, no further pause byte is requested until a resume pair has been sent. This holds however long the count stays at or above the threshold.
- R6: If the count falls below the threshold during the two-character wait, the pending pause is dropped and nothing is requested. A later crossing restarts the full wait.
- R7: While `enable` is low, `injReq` is low. Lowering `enable` for one edge clears any wait or send in progress. After `enable` returns high, a count at or above the threshold starts a fresh full wait.
- R8: After reset, `injReq` is low and the block is idle, not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns automatic flow control on |
| fifoCount | input | CNT_W | Receive FIFO fill count |
| trigSel | input | 2 | Threshold select |
| pauseA | input | 8 | First pause byte |
| pauseB | input | 8 | Second pause byte |
| resumeA | input | 8 | First resume byte |
| resumeB | input | 8 | Second resume byte |
| charTicks | input | CT_W | Clock cycles in one character time |
| injAck | input | 1 | Transmitter has taken the offered byte |
| injReq | output | 1 | A flow-control byte is offered |
| injByte | output | 8 | The offered byte |

## Verification
The bench builds the block with CNT_W = 6, so the count can range over a full 32-entry FIFO, and with CT_W = 8. Most scenarios run with `charTicks` = 4, giving an eight-cycle wait; one scenario uses `charTicks` = 2. This short wait lets the bench check the exact edge on which a pause starts, and cancel a wait partway through, within a few dozen cycles. Every `trigSel` value is driven to its threshold and to its release level, and also one count away from each, so both lookup tables are checked at their edges.

// File: rtl/swflow_pkg.sv
package swflow_pkg;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OFF1, SEL_OFF2, SEL_ON1, SEL_ON2
  } byteSel_e;

  typedef struct packed {
    logic     clrDelay;
    logic     runDelay;
    byteSel_e byteSel;
  } strobe_t;

  function automatic logic [4:0] trigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd8;
      2'd1:    return 5'd16;
      2'd2:    return 5'd24;
      default: return 5'd28;
    endcase
  endfunction

  function automatic logic [4:0] releaseLevel(input logic [1:0] sel);
    return {sel, 3'b000};
  endfunction

endpackage

// File: rtl/swflow_dp.sv
module swflow_dp
  import swflow_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int CT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic [7:0]       pauseA,
  input  logic [7:0]       pauseB,
  input  logic [7:0]       resumeA,
  input  logic [7:0]       resumeB,
  input  logic [CT_W-1:0]  charTicks,
  output logic             aboveTrig,
  output logic             atRelease,
  output logic             delayDone,
  output logic [7:0]       injByte
);
  localparam int DLY_W = CT_W + 1;
  localparam int LVL_W = (CNT_W > 5) ? CNT_W : 5;

  logic [DLY_W-1:0] delayCnt;
  logic [DLY_W-1:0] delayLimit;
  logic [LVL_W-1:0] countExt;
  logic [LVL_W-1:0] trigLvl;
  logic [LVL_W-1:0] relLvl;

  assign countExt = LVL_W'(fifoCount);
  assign trigLvl  = LVL_W'(trigLevel(trigSel));
  assign relLvl   = LVL_W'(releaseLevel(trigSel));

  assign aboveTrig = countExt >= trigLvl;
  assign atRelease = countExt <= relLvl;

  assign delayLimit = {charTicks, 1'b0};
  assign delayDone  = strobes.runDelay && ((delayCnt + 1'b1) >= delayLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrDelay) delayCnt <= '0;
    else if (strobes.runDelay)     delayCnt <= delayCnt + 1'b1;
  end

  always_comb begin
    case (strobes.byteSel)
      SEL_OFF1: injByte = pauseA;
      SEL_OFF2: injByte = pauseB;
      SEL_ON1:  injByte = resumeA;
      SEL_ON2:  injByte = resumeB;
      default:  injByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/swflow_ctl.sv
module swflow_ctl
  import swflow_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    aboveTrig,
  input  logic    atRelease,
  input  logic    delayDone,
  input  logic    injAck,
  output logic    injReq,
  output strobe_t strobes
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_OFF1, ST_OFF2, ST_HOLD, ST_ON1, ST_ON2
  } state_e;

  state_e state, stateNext;
  logic   sending;
  logic   taken;

  assign sending = (state == ST_OFF1) || (state == ST_OFF2) ||
                   (state == ST_ON1)  || (state == ST_ON2);
  assign injReq  = enable && sending;
  assign taken   = injReq && injAck;

  always_comb begin
    stateNext = state;
    if (!enable) stateNext = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (aboveTrig) stateNext = ST_WAIT;
        ST_WAIT: begin
          if (!aboveTrig)     stateNext = ST_IDLE;
          else if (delayDone) stateNext = ST_OFF1;
        end
        ST_OFF1: if (taken) stateNext = ST_OFF2;
        ST_OFF2: if (taken) stateNext = ST_HOLD;
        ST_HOLD: if (atRelease) stateNext = ST_ON1;
        ST_ON1:  if (taken) stateNext = ST_ON2;
        ST_ON2:  if (taken) stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.runDelay = (state == ST_WAIT);
    strobes.clrDelay = (state != ST_WAIT);
    case (state)
      ST_OFF1: strobes.byteSel = SEL_OFF1;
      ST_OFF2: strobes.byteSel = SEL_OFF2;
      ST_ON1:  strobes.byteSel = SEL_ON1;
      ST_ON2:  strobes.byteSel = SEL_ON2;
      default: strobes.byteSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
  import swflow_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int CT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic [7:0]       pauseA,
  input  logic [7:0]       pauseB,
  input  logic [7:0]       resumeA,
  input  logic [7:0]       resumeB,
  input  logic [CT_W-1:0]  charTicks,
  input  logic             injAck,
  output logic             injReq,
  output logic [7:0]       injByte
);
  strobe_t strobes;
  logic    aboveTrig, atRelease, delayDone;

  swflow_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .aboveTrig(aboveTrig), .atRelease(atRelease), .delayDone(delayDone),
    .injAck(injAck), .injReq(injReq), .strobes(strobes)
  );

  swflow_dp #(.CNT_W(CNT_W), .CT_W(CT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fifoCount(fifoCount), .trigSel(trigSel),
    .pauseA(pauseA), .pauseB(pauseB), .resumeA(resumeA), .resumeB(resumeB),
    .charTicks(charTicks),
    .aboveTrig(aboveTrig), .atRelease(atRelease), .delayDone(delayDone),
    .injByte(injByte)
  );
endmodule

// File: rtl/swflow_chk.sv
module swflow_chk
  import swflow_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       injReq,
  input logic       injAck,
  input logic [7:0] injByte,
  input strobe_t    strobes
);
  // R3: an offered byte that has not been taken stays on the port
  assert_hold_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    (injReq && !injAck && enable) |=> (!enable || (injReq && $stable(injByte))));

  // R3: taking the first byte of a pair leads straight to the second
  assert_pair_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (injReq && injAck && enable &&
     (strobes.byteSel == SEL_OFF1 || strobes.byteSel == SEL_ON1)) |=> (!enable || injReq));

  // R7: one low cycle of enable leaves no request behind it
  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !injReq);

  // R2: a pause request starts only out of the running wait
  assert_pause_after_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(injReq) && strobes.byteSel == SEL_OFF1) |-> $past(strobes.runDelay));
endmodule

bind swflow_ctrl swflow_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .injReq(injReq),
  .injAck(injAck), .injByte(injByte), .strobes(strobes)
);

// File: tb/sim_swflow_ctrl.sv
`timescale 1ns/1ps
module sim_swflow_ctrl;
  localparam int CNT_W = 6;
  localparam int CT_W  = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] fifoCount = '0;
  logic [1:0]       trigSel = 2'd0;
  logic [7:0]       pauseA = 8'h13, pauseB = 8'h93, resumeA = 8'h11, resumeB = 8'h91;
  logic [CT_W-1:0]  charTicks = 8'd4;
  logic             injAck = 1'b0;
  logic             injReq;
  logic [7:0]       injByte;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swflow_ctrl #(.CNT_W(CNT_W), .CT_W(CT_W)) u0 (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // no request during n cycles
  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (injReq) seen++;
    end
    chk(req, "cycles with request", seen, 0);
  endtask

  task automatic takeByte(input string req, input logic [7:0] exp);
    chk(req, "request", injReq, 1);
    chk(req, "byte", injByte, exp);
    injAck = 1'b1;
    step(1);
    injAck = 1'b0;
  endtask

  // from idle: raise count, check exact start of pause pair, take it
  task automatic pauseAt(input string req, input int cnt, input int ticks);
    fifoCount = CNT_W'(cnt);
    step(2 * ticks);
    chk(req, "request before wait ends", injReq, 0);
    step(1);
    takeByte(req, pauseA);
    takeByte("R3", pauseB);
    chk("R3", "request after pair", injReq, 0);
  endtask

  task automatic resumeAt(input string req, input int cnt);
    fifoCount = CNT_W'(cnt);
    step(1);
    takeByte(req, resumeA);
    takeByte("R3", resumeB);
    chk("R3", "request after resume pair", injReq, 0);
  endtask

  task automatic tReset();
    rstN = 1'b0; enable = 1'b0; fifoCount = '0; injAck = 1'b0;
    step(3);
    chk("R8", "request in reset", injReq, 0);
    rstN = 1'b1; enable = 1'b1;
    step(1);
    chk("R8", "request after reset", injReq, 0);
    // idle, not paused: count 0 must not start a resume pair
    quiet("R8", 5);
  endtask

  task automatic tBasic();
    trigSel = 2'd0;
    fifoCount = 6'd7;
    quiet("R1", 20);
    pauseAt("R2", 8, 4);
    quiet("R5", 30);
    fifoCount = 6'd1;
    quiet("R4", 10);
    resumeAt("R4", 0);
  endtask

  task automatic tLevels();
    for (int s = 1; s < 4; s++) begin
      int trig = (s == 3) ? 28 : (s + 1) * 8;
      int rel  = s * 8;
      trigSel = 2'(s);
      fifoCount = CNT_W'(trig - 1);
      quiet("R1", 12);
      pauseAt("R1", trig, 4);
      fifoCount = CNT_W'(rel + 1);
      quiet("R4", 8);
      resumeAt("R4", rel);
      fifoCount = CNT_W'(rel);
      step(1);
    end
  endtask

  task automatic tHoldAck();
    trigSel = 2'd0;
    fifoCount = 6'd20;
    step(8);
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R3", "held request", injReq, 1);
      chk("R3", "held byte", injByte, pauseA);
    end
    takeByte("R3", pauseA);
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R3", "held second byte", injByte, pauseB);
    end
    takeByte("R3", pauseB);
    resumeAt("R4", 0);
  endtask

  task automatic tCancel();
    trigSel = 2'd1;
    fifoCount = 6'd16;
    step(5);
    fifoCount = 6'd15;
    quiet("R6", 20);
    pauseAt("R6", 17, 4);
    resumeAt("R4", 8);
  endtask

  task automatic tDisable();
    trigSel = 2'd0;
    fifoCount = 6'd9;
    step(5);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    pauseAt("R7", 9, 4);
    enable = 1'b0;
    fifoCount = 6'd0;
    quiet("R7", 5);
    enable = 1'b1;
    quiet("R7", 5);
    fifoCount = 6'd12;
    step(8);
    step(1);
    chk("R7", "request at wait end", injReq, 1);
    enable = 1'b0;
    #1;
    chk("R7", "request while disabled", injReq, 0);
    step(1);
    fifoCount = 6'd0;
    enable = 1'b1;
    quiet("R7", 5);
  endtask

  task automatic tShortTicks();
    charTicks = 8'd2;
    trigSel = 2'd0;
    pauseAt("R2", 10, 2);
    resumeAt("R4", 0);
    charTicks = 8'd4;
  endtask

  initial begin
    step(1);
    tReset();
    tBasic();
    tLevels();
    tHoldAck();
    tCancel();
    tDisable();
    tShortTicks();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule